// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for a four-beat burst into a synchronous memory. On each clock edge that is not suspended it does one of two things. It either takes a new starting address from outside, or it moves on to the next beat of the burst already in progress. The upper address bits keep the value from the load. The two low bits follow one of two beat orders. In interleaved order, each beat's low bits are the start value XOR the beat number. In linear order, they are the start value plus the beat number, wrapping modulo four.

The beat order is taken from the mode input at the moment of each load, so one burst always keeps a single order. A suspend input freezes every register, and on such an edge all other inputs are ignored. The outputs come straight from registers through a small mapping stage, so a load or an advance shows up on the outputs right after the edge that sampled it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_ni low), and after it is released until the first unsuspended edge, addr_o is zero and beat_o is zero.
- R2: An edge with susp_i low and adv_i low loads the burst. Afterwards addr_o equals the sampled addr_i and beat_o is 0.
- R3: An edge with susp_i low and adv_i high raises beat_o by one, modulo 4. The addr_i value on that edge has no effect on addr_o.
- R4: When mode_i was 1 at the load, addr_o[1:0] equals the loaded low bits XOR beat_o. A start of 1 gives the order 1,0,3,2.
- R5: When mode_i was 0 at the load, addr_o[1:0] equals (loaded low bits + beat_o) mod 4. A start of 1 gives the order 1,2,3,0.
- R6: An advance after beat 3 returns to beat 0 of the same burst, with the starting low bits. addr_o[ADDR_W-1:2] never changes on an advance, so there is no carry into the upper bits.
- R7: On an edge with susp_i high, addr_o and beat_o keep their values, whatever adv_i, mode_i and addr_i are.
- R8: A change of mode_i on advance edges does not change the order of the burst in progress.
- R9: A load in the middle of a burst abandons the old burst. beat_o goes to 0 and addr_o takes the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every input is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| susp_i | input | 1 | High freezes all state for that edge |
| adv_i | input | 1 | 1 = advance to the next beat, 0 = load a new start address |
| mode_i | input | 1 | Beat order for the next load: 1 = interleaved, 0 = linear |
| addr_i | input | ADDR_W | External starting address |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Suspend and load can coincide: an edge can carry susp_i high together with adv_i low, a fresh addr_i and a different mode_i. The bench drives this combination in the middle of a burst. It passes only if address, beat and order all come out unchanged, and if the next advance continues the old burst. The bench also loads in the same cycle that would otherwise have been the wrap from beat 3. There it expects the new address at beat 0 rather than the old start.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bst_beat_ctr.sv
module bst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (!hold_i) begin
      if (step_i) beat_d = beat_q + ONE;
      else        beat_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (!hold_i) beat_q <= beat_d;
  end

  assign beat_o = beat_q;

  // R7
  beat_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(beat_o));
  // R3
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && step_i) |=> beat_o == $past(beat_o) + ONE);
  // R2
  beat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !step_i) |=> beat_o == '0);
endmodule

// File: rtl/bst_start_reg.sv
module bst_start_reg
  import bst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] start_o,
  output order_e            order_o
);
  logic [ADDR_W-1:0] start_q, start_d;
  order_e            order_q, order_d;
  logic              take;

  assign take = load_i && !hold_i;

  always_comb begin
    start_d = start_q;
    order_d = order_q;
    if (take) begin
      start_d = addr_i;
      order_d = order_e'(mode_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      order_q <= ORD_LINEAR;
    end else if (take) begin
      start_q <= start_d;
      order_q <= order_d;
    end
  end

  assign start_o = start_q;
  assign order_o = order_q;

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !hold_i) |=> start_o == $past(addr_i));
  // R8
  start_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i || !load_i) |=> ($stable(start_o) && $stable(order_o)));
endmodule

// File: rtl/bst_order_map.sv
module bst_order_map
  import bst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = ilv_low;
      default:        low_o = lin_low;
    endcase
  end

  // R4 R5: the beat number is recovered from the mapped bits
  always_comb begin
    if (order_i == ORD_INTERLEAVE)
      map_ilv_chk: assert ((low_o ^ start_i) == beat_i);
    else
      map_lin_chk: assert (BEAT_W'(low_o - start_i) == beat_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              susp_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int BEAT_W = 2;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start;
  order_e            order;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  bst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (susp_i),
    .step_i (adv_i),
    .beat_o (beat)
  );

  bst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (susp_i),
    .load_i  (!adv_i),
    .addr_i  (addr_i),
    .mode_i  (mode_i),
    .start_o (start),
    .order_o (order)
  );

  bst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (start[BEAT_W-1:0]),
    .beat_i  (beat),
    .order_i (order),
    .low_o   (low)
  );

  assign addr_o = {start[ADDR_W-1:BEAT_W], low};
  assign beat_o = beat;

  // R6
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !susp_i) |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  // R7
  addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_i |=> $stable(addr_o));
  // R6
  wrap_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !susp_i && beat_o == 2'd3) |=> addr_o[BEAT_W-1:0] == start[BEAT_W-1:0]);
  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && beat_o == '0));

  logic unused_hi;
  assign unused_hi = (HI_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          susp_i = 1'b0;
  logic          adv_i = 1'b1;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .susp_i(susp_i), .adv_i(adv_i),
    .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] n, logic m);
    return m ? (s ^ n) : 2'(s + n);
  endfunction

  task automatic chk(string req, logic [AW-1:0] got_a, logic [AW-1:0] exp_a,
                     logic [1:0] got_b, logic [1:0] exp_b);
    n_run++;
    if (got_a !== exp_a || got_b !== exp_b) begin
      n_fail++;
      $display("FAIL %s addr=%h/beat=%0d expected addr=%h/beat=%0d",
               req, got_a, got_b, exp_a, exp_b);
    end
  endtask

  task automatic edge_drive(logic s, logic a, logic m, logic [AW-1:0] ad);
    @(negedge clk_i);
    susp_i = s; adv_i = a; mode_i = m; addr_i = ad;
    @(posedge clk_i);
    #2;
  endtask

  task automatic run_burst(string req, logic [AW-1:0] st, logic m);
    edge_drive(1'b0, 1'b0, m, st);
    chk({req, " R2 load"}, addr_o, st, beat_o, 2'd0);
    for (int n = 1; n < 6; n++) begin
      edge_drive(1'b0, 1'b1, ~m, AW'(32'h5A5A5 * n));
      chk({req, " R3 R6 step"}, addr_o,
          {st[AW-1:2], exp_low(st[1:0], 2'(n), m)}, beat_o, 2'(n));
    end
  endtask

  task automatic t_reset();
    #3;
    chk("R1 during reset", addr_o, '0, beat_o, 2'd0);
    @(negedge clk_i); rst_ni = 1'b1; susp_i = 1'b1;
    @(posedge clk_i); #2;
    chk("R1 after release", addr_o, '0, beat_o, 2'd0);
  endtask

  task automatic t_orders();
    run_burst("R4 ilv s1", 20'hABCD1, 1'b1);
    run_burst("R5 lin s1", 20'h12341, 1'b0);
    run_burst("R5 R6 lin s3", 20'hFFFFF, 1'b0);
    run_burst("R4 ilv s2", 20'h00002, 1'b1);
  endtask

  task automatic t_suspend();
    edge_drive(1'b0, 1'b0, 1'b1, 20'h33331);
    edge_drive(1'b0, 1'b1, 1'b1, '0);
    chk("R4 pre-suspend", addr_o, 20'h33330, beat_o, 2'd1);
    edge_drive(1'b1, 1'b0, 1'b0, 20'h77776);
    chk("R7 suspend vs load", addr_o, 20'h33330, beat_o, 2'd1);
    edge_drive(1'b1, 1'b1, 1'b0, 20'h11111);
    chk("R7 suspend vs advance", addr_o, 20'h33330, beat_o, 2'd1);
    edge_drive(1'b0, 1'b1, 1'b0, 20'h11111);
    chk("R7 R4 resume", addr_o, 20'h33333, beat_o, 2'd2);
  endtask

  task automatic t_mode_hold();
    edge_drive(1'b0, 1'b0, 1'b0, 20'h40002);
    edge_drive(1'b0, 1'b1, 1'b1, '0);
    chk("R8 linear kept", addr_o, 20'h40003, beat_o, 2'd1);
    edge_drive(1'b0, 1'b1, 1'b1, '0);
    chk("R8 linear kept 2", addr_o, 20'h40000, beat_o, 2'd2);
  endtask

  task automatic t_reload();
    edge_drive(1'b0, 1'b0, 1'b0, 20'h50001);
    edge_drive(1'b0, 1'b1, 1'b0, '0);
    edge_drive(1'b0, 1'b1, 1'b0, '0);
    edge_drive(1'b0, 1'b1, 1'b0, '0);
    chk("R9 at beat3", addr_o, 20'h50000, beat_o, 2'd3);
    edge_drive(1'b0, 1'b0, 1'b1, 20'h6ABC3);
    chk("R9 reload instead of wrap", addr_o, 20'h6ABC3, beat_o, 2'd0);
    edge_drive(1'b0, 1'b1, 1'b0, '0);
    chk("R9 R4 new order", addr_o, 20'h6ABC2, beat_o, 2'd1);
  endtask

  task automatic t_reset_mid();
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk("R1 async mid-burst", addr_o, '0, beat_o, 2'd0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_orders();
    t_suspend();
    t_mode_hold();
    t_reload();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule